// File: doc/BRIEF.md
# Scroll Position and Video Address Latch

This block keeps the scroll position and the video memory address for a tile-based video controller. A processor sets it through three write ports: a control port, a scroll port and an address port. Internally it holds a 15-bit staging word and a 15-bit live address word. The staging word is split into fine Y (3 bits, the top), nametable select (2 bits), coarse Y (5 bits) and coarse X (5 bits, the bottom). A separate 3-bit register holds fine X. The scroll port and the address port each take two bytes in sequence. They share one phase flag that picks the first or the second byte, and a status read returns that flag to the first phase.

The live word is the video address and the scroll position at the same time. Its top three bits lie where the upper address bits would be, so they double as the fine vertical scroll inside a tile. The block also works out the nametable tile fetch address from the coarse fields and the nametable bits of the live word.

Top module: `scroll_addr_reg`

## Requirements
- R1: After a synchronous active-low reset, `vaddr`, `fine_x` and `tile_addr` read zero, and the next address-port write is taken as a first write.
- R2: A first write to the address port (`wr_sel` = 2'b10) loads data bits 5:0 into staging bits 13:8 and clears staging bit 14. That sets fine Y bits 1:0, the nametable select and coarse Y bits 4:3, and forces fine Y bit 2 to zero. `vaddr` is left unchanged.
- R3: A second write to the address port loads all eight data bits into staging bits 7:0. On the same clock edge, the whole updated staging word is copied into `vaddr`, so the new value appears one cycle after the write.
- R4: The phase flag flips on every write to the scroll port or the address port, and either port advances the other's sequence.
- R5: `stat_rd` returns the phase flag to the first phase. If it arrives together with a write, the write uses the phase it finds and the flag ends in the first phase.
- R6: A first write to the scroll port (`wr_sel` = 2'b01) puts data bits 2:0 into `fine_x` and data bits 7:3 into staging coarse X.
- R7: A second write to the scroll port puts data bits 7:3 into staging coarse Y and data bits 2:0 into staging fine Y. `vaddr` does not change until the next second address write.
- R8: A write to the control port (`wr_sel` = 2'b00) puts data bits 1:0 into the staging nametable select and does not move the phase flag.
- R9: `tile_addr` equals coarse X + 32 × coarse Y + 1024 × nametable bit 0 + 2048 × nametable bit 1, taken from the live word.
- R10: A write with `wr_sel` = 2'b11 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Processor write strobe, one cycle per byte |
| wr_sel | input | 2 | Port select: 00 control, 01 scroll, 10 address, 11 none |
| wr_data | input | 8 | Write data byte |
| stat_rd | input | 1 | Status read; returns the phase flag to the first phase |
| vaddr | output | 15 | Live video address / scroll word |
| fine_x | output | 3 | Fine horizontal scroll |
| tile_addr | output | 12 | Tile fetch address within nametable space |

## Verification
Nothing in the staging word reaches the ports until a second address write copies it. A corrupted staging field therefore stays hidden until that copy, and even then the low byte is overwritten, so only bits 14:8 show the earlier scroll or control writes. A wrong phase flag shows up one cycle after the next address write: either a copy happens that should not, or an expected copy is missing. A wrong fine X value appears on `fine_x` in the cycle right after the scroll write. The bench therefore reads these values back by finishing each sequence with a single second address write.

// File: rtl/scroll_pkg.sv
// Shared widths, port select codes and the field layout of the scroll/address word.
package scroll_pkg;
    parameter int FINE_W = 3;
    parameter int NT_W   = 2;
    parameter int CRS_W  = 5;
    parameter int DATA_W = 8;
    localparam int ADDR_W = FINE_W + NT_W + 2 * CRS_W;
    localparam int TILE_W = NT_W + 2 * CRS_W;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'b00,
        SEL_SCROLL = 2'b01,
        SEL_ADDR   = 2'b10,
        SEL_NONE   = 2'b11
    } port_sel_e;

    // MSB first: fine Y, nametable select, coarse Y, coarse X.
    typedef struct packed {
        logic [FINE_W-1:0] fy;
        logic [NT_W-1:0]   nt;
        logic [CRS_W-1:0]  cy;
        logic [CRS_W-1:0]  cx;
    } loc_t;
endpackage

// File: rtl/wr_phase.sv
// Shared first/second write phase flag for the scroll and address ports.
// Assumes a write strobe lasts one cycle per byte; a status read wins over a flip.
module wr_phase
    import scroll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  port_sel_e sel,
    input  logic      stat_rd,
    output logic      phase
);
    logic pair_wr;

    // Writes that take part in the two-byte sequence.
    always_comb pair_wr = wr_en && (sel == SEL_SCROLL || sel == SEL_ADDR);

    // Phase register: cleared by status read, flipped by paired-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= 1'b0;
        else if (stat_rd) phase <= 1'b0;
        else if (pair_wr) phase <= ~phase;
    end

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !phase); // R5
    AST_PAIR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_SCROLL || sel == SEL_ADDR) && !stat_rd) |=> (phase != $past(phase))); // R4
    AST_CTRL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL && !stat_rd) |=> $stable(phase)); // R8
    AST_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE && !stat_rd) |=> $stable(phase)); // R10
endmodule

// File: rtl/tmp_loader.sv
// Staging word and fine X register, loaded by the control, scroll and address ports.
// Presents the next staging value and a copy request so the live word can
// take the updated staging word on the same edge as the second address byte.
module tmp_loader
    import scroll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] data,
    input  logic              phase,
    output loc_t              tmp_next,
    output logic              copy_req,
    output logic [FINE_W-1:0] fine_x
);
    loc_t              tmp_q;
    logic [FINE_W-1:0] fx_next;

    // Next staging value and fine X for the port and phase being written.
    always_comb begin
        tmp_next = tmp_q;
        fx_next  = fine_x;
        copy_req = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: tmp_next.nt = data[NT_W-1:0];
                SEL_SCROLL: begin
                    if (!phase) begin
                        tmp_next.cx = data[DATA_W-1 -: CRS_W];
                        fx_next     = data[FINE_W-1:0];
                    end else begin
                        tmp_next.cy = data[DATA_W-1 -: CRS_W];
                        tmp_next.fy = data[FINE_W-1:0];
                    end
                end
                SEL_ADDR: begin
                    if (!phase) begin
                        tmp_next.fy        = {1'b0, data[5:4]};
                        tmp_next.nt        = data[3:2];
                        tmp_next.cy[4:3]   = data[1:0];
                    end else begin
                        tmp_next.cy[2:0]   = data[7:5];
                        tmp_next.cx        = data[4:0];
                        copy_req           = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Staging and fine X registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q  <= '0;
            fine_x <= '0;
        end else begin
            tmp_q  <= tmp_next;
            fine_x <= fx_next;
        end
    end

    AST_FX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SCROLL && !phase) |=> (fine_x == $past(data[FINE_W-1:0]))); // R6
    AST_FY_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ADDR && !phase) |=> (tmp_q.fy[FINE_W-1] == 1'b0)); // R2
    AST_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(tmp_q) && $stable(fine_x))); // R10
endmodule

// File: rtl/tile_addr_gen.sv
// Tile fetch address from the coarse fields and the nametable select bits.
// Each nametable bit adds one nametable size scaled by its bit weight.
module tile_addr_gen
    import scroll_pkg::*;
(
    input  logic [NT_W-1:0]   nt,
    input  logic [CRS_W-1:0]  cy,
    input  logic [CRS_W-1:0]  cx,
    output logic [TILE_W-1:0] tile
);
    localparam int ROW_SHIFT = CRS_W;
    localparam int NT_SHIFT  = 2 * CRS_W;

    // Weighted sum: column + rows of 2**CRS_W tiles + whole nametables.
    always_comb begin
        tile = TILE_W'(cx) + (TILE_W'(cy) << ROW_SHIFT);
        for (int i = 0; i < NT_W; i++) begin
            tile = tile + (TILE_W'(nt[i]) << (NT_SHIFT + i));
        end
    end
endmodule

// File: rtl/scroll_addr_reg.sv
// Scroll position and video address latch. Holds the live address word,
// copies the staging word into it on a second address-port byte, and
// presents fine X and the tile fetch address. Assumes one-cycle write strobes.
module scroll_addr_reg
    import scroll_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                stat_rd,
    output logic [ADDR_W-1:0]   vaddr,
    output logic [FINE_W-1:0]   fine_x,
    output logic [TILE_W-1:0]   tile_addr
);
    port_sel_e sel;
    logic      phase;
    loc_t      tmp_next;
    logic      copy_req;
    loc_t      cur_q;

    // Decode the port select into the shared enum.
    always_comb sel = port_sel_e'(wr_sel);

    wr_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .stat_rd (stat_rd),
        .phase   (phase)
    );

    tmp_loader u_tmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .data     (wr_data),
        .phase    (phase),
        .tmp_next (tmp_next),
        .copy_req (copy_req),
        .fine_x   (fine_x)
    );

    // Live address word: takes the updated staging word on a copy request.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (copy_req) cur_q <= tmp_next;
    end

    tile_addr_gen u_tile (
        .nt   (cur_q.nt),
        .cy   (cur_q.cy),
        .cx   (cur_q.cx),
        .tile (tile_addr)
    );

    // Drive the address output from the live word.
    always_comb vaddr = cur_q;

    AST_COPY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10 && phase) |=> (vaddr[7:0] == $past(wr_data))); // R3
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'b10 && phase) |=> $stable(vaddr)); // R7
    AST_TILE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (tile_addr == vaddr[TILE_W-1:0])); // R9
endmodule

// File: tb/scroll_addr_reg_test.sv
module scroll_addr_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [7:0]  wr_data = 8'h00;
    logic        stat_rd = 1'b0;
    logic [14:0] vaddr;
    logic [2:0]  fine_x;
    logic [11:0] tile_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] P_CTRL = 2'b00, P_SCR = 2'b01, P_ADR = 2'b10, P_NONE = 2'b11;

    always #10 clk = ~clk;

    scroll_addr_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stat_rd(stat_rd),
        .vaddr(vaddr), .fine_x(fine_x), .tile_addr(tile_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write cycle driven at a falling edge; outputs are settled at the next one.
    task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic st = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d; stat_rd = st;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = P_NONE; stat_rd = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 vaddr", vaddr, 0);
        chk("R1 fine_x", fine_x, 0);
        chk("R1 tile_addr", tile_addr, 0);
    endtask

    task automatic t_addr_pair();
        wr(P_ADR, 8'h3F);
        chk("R2 no copy on first", vaddr, 0);
        wr(P_ADR, 8'hA5);
        chk("R3 copy", vaddr, 15'h3FA5);
        // 5 + 32*29 + 1024 + 2048 = 4005
        chk("R9 tile", tile_addr, 4005);
    endtask

    task automatic t_fy_top_clear();
        wr(P_SCR, 8'h1E);
        chk("R6 fine_x", fine_x, 6);
        wr(P_SCR, 8'h07);              // fine Y = 7, coarse Y = 0
        chk("R7 no copy on scroll", vaddr, 15'h3FA5);
        wr(P_ADR, 8'h00);
        wr(P_ADR, 8'h00);
        chk("R2 fine Y bit2 cleared", vaddr, 0);
    endtask

    task automatic t_scroll_fy();
        wr(P_SCR, 8'h00);
        chk("R6 fine_x zero", fine_x, 0);
        wr(P_SCR, 8'hFD);              // coarse Y = 31, fine Y = 5
        chk("R7 hold", vaddr, 0);
        wr(P_SCR, 8'h03);              // phase now second
        chk("R6 fine_x 3", fine_x, 3);
        wr(P_ADR, 8'h12);              // second address byte -> copy
        chk("R4 R7 shared phase copy", vaddr, 15'h5312);
    endtask

    task automatic t_ctrl();
        wr(P_SCR, 8'h00);              // phase -> second
        wr(P_CTRL, 8'h02);             // nametable = 2, phase kept
        chk("R8 no copy on ctrl", vaddr, 15'h5312);
        wr(P_ADR, 8'h77);
        chk("R8 nametable and phase kept", vaddr, 15'h5B77);
        chk("R9 tile after ctrl", tile_addr, 12'hB77);
    endtask

    task automatic t_status();
        wr(P_SCR, 8'h00);              // phase -> second
        status_read();
        wr(P_ADR, 8'h01);
        chk("R5 first after status", vaddr, 15'h5B77);
        wr(P_ADR, 8'h00);
        chk("R5 pair after status", vaddr, 15'h0100);
        wr(P_SCR, 8'h00);              // phase -> second
        wr(P_ADR, 8'h22, 1'b1);        // second write with status read together
        chk("R5 write uses old phase", vaddr, 15'h0122);
        wr(P_ADR, 8'h05);
        chk("R5 status wins over flip", vaddr, 15'h0122);
        wr(P_ADR, 8'h33);
        chk("R5 pair completes", vaddr, 15'h0533);
    endtask

    task automatic t_none();
        wr(P_SCR, 8'h2D);              // fine_x = 5, phase -> second
        status_read();                 // phase -> first
        wr(P_NONE, 8'hFF);
        chk("R10 vaddr kept", vaddr, 15'h0533);
        chk("R10 fine_x kept", fine_x, 5);
        wr(P_ADR, 8'h2A);
        chk("R10 phase kept", vaddr, 15'h0533);
        wr(P_ADR, 8'h11);
        chk("R10 staging kept", vaddr, 15'h2A11);
    endtask

    task automatic t_reset_again();
        wr(P_SCR, 8'h07);              // phase -> second
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 vaddr after reset", vaddr, 0);
        wr(P_ADR, 8'h15);
        chk("R1 phase reset", vaddr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_pair();
        t_fy_top_clear();
        t_scroll_fy();
        t_ctrl();
        t_status();
        t_none();
        t_reset_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule